// File: doc/BRIEF.md
# Correctable ECC Error Logger

This block records single-bit (correctable) ECC events that a memory-controller bridge reports to it. Each event arrives as a one-cycle strobe with a 29-bit address. The block keeps the addresses of the oldest unread events in a two-entry queue that software reads and pops. It keeps a saturating count of all events. It compares that count with a programmable threshold to raise a correctable-error status bit and an interrupt.

The block does not detect, decode or correct errors. Single-bit errors that the bridge escalates to fatal, because several of them landed in one burst, are presented on the same event input. They are counted and logged exactly like any other event.

Software uses a small register port: a write strobe, a 3-bit register select, a 32-bit write word and a combinational read word. The select codes are:
- 0: address log
- 1: error count
- 2: threshold
- 3: status
- 4: interrupt enable

Top module: `ce_err_logger`

## Requirements
- R1: The address queue holds at most 2 entries and keeps the oldest unread events. An event that arrives while the queue is full, with no pop in the same cycle, is dropped. After reset the queue is empty, the count is 0, the threshold is 1 and the status and enable bits are 0.
- R2: A read of select 0 and the `log_head` output both show the head entry, zero-extended. A write of exactly 32'h1 to select 0 removes the head. A write of any other value to select 0 changes nothing.
- R3: Two events with the same address occupy two separate queue entries.
- R4: Every event raises the count by one, as read at select 1 and on `err_count`, unless the count is saturated or cleared in the same cycle.
- R5: When an event brings the count to a value equal to or greater than the threshold (select 2, low 8 bits) while the comparator is armed, status bit 3 (select 3) is set at that clock edge.
- R6: After status bit 3 has been set once, it is not set again by further events until software clears the count. The comparator is armed after reset and after every count clear.
- R7: `irq` is high exactly when status bit 3 is set and bit 0 of the enable register (select 4) is 1.
- R8: The count saturates at 255 and does not wrap.
- R9: A write to select 3 with bit 3 set clears status bit 3. A threshold crossing in the same cycle takes priority and leaves the bit set.
- R10: When the queue is empty, select 0 reads zero and a pop write is ignored. A following event still becomes the head.
- R11: When the queue is full and an event and a pop occur in the same cycle, the pop is applied first and the new address is stored.
- R12: Any write to select 1 sets the count to 0. An event in the same cycle is not counted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| err_valid | input | 1 | One-cycle strobe for a correctable error event |
| err_addr | input | 29 | Address carried by the event |
| sw_wr | input | 1 | Register write strobe |
| sw_sel | input | 3 | Register select |
| sw_wdata | input | 32 | Register write word |
| sw_rdata | output | 32 | Register read word for the current select |
| log_head | output | 29 | Head entry of the address queue, zero when empty |
| err_count | output | 8 | Saturating event count |
| status_raw | output | 1 | Correctable-error status (bit 3 of select 3) |
| irq | output | 1 | Correctable-error interrupt |

## Verification
The bench sweeps every threshold from 0 to 4, each with a dense mix of events, pops, count clears and status clears. Every cycle is compared against an arithmetic model. It also aims directed cycles at the collisions:
- A push and a pop on a full queue. A design that drops here loses the newest address.
- A pop on an empty queue. A careless design underflows its level and shows stale data.
- An event that coincides with a count clear. A wrong design leaves the count at 1.
- A status clear that coincides with a threshold crossing. A wrong design loses the interrupt.

It also drives 260 events to show that the count sticks at 255 instead of wrapping. It checks that a second crossing stays silent until the count is cleared, which a level-compare design would miss.

// File: rtl/ce_pkg.sv
// Package: register select codes and field positions shared by the
// correctable-error logger and its checker.
package ce_pkg;
    typedef enum logic [2:0] {
        SEL_LOG  = 3'd0,
        SEL_CNT  = 3'd1,
        SEL_THR  = 3'd2,
        SEL_STAT = 3'd3,
        SEL_IEN  = 3'd4
    } sel_e;

    // status bit position inside the status register
    localparam int STAT_CE_BIT = 3;
    // write value that removes the head of the address queue
    localparam int POP_CODE    = 1;
endpackage

// File: rtl/ce_addr_fifo.sv
// Module: ce_addr_fifo
// Shift-style address queue of DEPTH entries; slot 0 is the head.
// Assumes: pop is applied before push in the same cycle, so a full queue
// accepts a push that coincides with a pop. Pops on an empty queue and
// pushes on a full queue (without pop) are ignored.
module ce_addr_fifo #(
    parameter int ADDR_W = 29,
    parameter int DEPTH  = 2
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     push_i,
    input  logic [ADDR_W-1:0]        addr_i,
    input  logic                     pop_i,
    output logic [ADDR_W-1:0]        head_o,
    output logic [$clog2(DEPTH+1)-1:0] level_o
);
    localparam int LVL_W = $clog2(DEPTH + 1);

    logic [ADDR_W-1:0] slot_q [DEPTH];
    logic [LVL_W-1:0]  level_q;
    logic [LVL_W-1:0]  level_after_pop;
    logic              pop_ok;
    logic              push_ok;

    // Qualify requests against the current fill level.
    always_comb begin
        pop_ok          = pop_i && (level_q != '0);
        level_after_pop = level_q - LVL_W'(pop_ok);
        push_ok         = push_i && (level_after_pop < LVL_W'(DEPTH));
    end

    // Fill level tracking.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            level_q <= '0;
        end else begin
            level_q <= level_after_pop + LVL_W'(push_ok);
        end
    end

    // One storage slot per entry: shift on pop, write at the free position.
    for (genvar i = 0; i < DEPTH; i++) begin : g_slot
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                slot_q[i] <= '0;
            end else if (push_ok && (level_after_pop == LVL_W'(i))) begin
                slot_q[i] <= addr_i;
            end else if (pop_ok) begin
                if (i < DEPTH - 1) begin
                    slot_q[i] <= slot_q[(i < DEPTH - 1) ? i + 1 : i];
                end
            end
        end
    end

    // Head view reads zero when empty.
    always_comb begin
        head_o  = (level_q != '0) ? slot_q[0] : '0;
        level_o = level_q;
    end
endmodule

// File: rtl/ce_err_counter.sv
// Module: ce_err_counter
// Saturating event counter with a one-shot threshold comparator.
// Assumes: clear has priority over an increment in the same cycle; the
// comparator is armed after reset and after each clear, and disarms after
// it fires once.
module ce_err_counter #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             inc_i,
    input  logic             clr_i,
    input  logic [CNT_W-1:0] thr_i,
    output logic [CNT_W-1:0] count_o,
    output logic             fire_o
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    logic [CNT_W-1:0] count_q;
    logic [CNT_W-1:0] count_inc;
    logic             armed_q;

    // Saturating next value and threshold crossing detection.
    always_comb begin
        count_inc = (count_q == CNT_MAX) ? CNT_MAX : count_q + 1'b1;
        fire_o    = inc_i && !clr_i && armed_q && (count_inc >= thr_i);
    end

    // Counter register: clear wins, else increment on an event.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count_q <= '0;
        end else if (clr_i) begin
            count_q <= '0;
        end else if (inc_i) begin
            count_q <= count_inc;
        end
    end

    // Arm flag: re-armed by clear, dropped by a firing.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            armed_q <= 1'b1;
        end else if (clr_i) begin
            armed_q <= 1'b1;
        end else if (fire_o) begin
            armed_q <= 1'b0;
        end
    end

    assign count_o = count_q;
endmodule

// File: rtl/ce_sw_regs.sv
// Module: ce_sw_regs
// Software register decode: pop and clear strobes, threshold and enable
// storage, the sticky status bit and the read multiplexer.
// Assumes: a threshold firing has priority over a write-1-to-clear.
module ce_sw_regs #(
    parameter int ADDR_W  = 29,
    parameter int CNT_W   = 8,
    parameter int DATA_W  = 32,
    parameter int THR_RST = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_i,
    input  logic [2:0]        sel_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  logic [ADDR_W-1:0] head_i,
    input  logic [CNT_W-1:0]  count_i,
    input  logic              fire_i,
    output logic [DATA_W-1:0] rdata_o,
    output logic              pop_o,
    output logic              clr_o,
    output logic [CNT_W-1:0]  thr_o,
    output logic              status_o,
    output logic              irq_o
);
    import ce_pkg::*;

    logic [CNT_W-1:0] thr_q;
    logic             ien_q;
    logic             stat_q;
    logic             wr_thr;
    logic             wr_ien;
    logic             wr_stat_clr;

    // Decode write strobes per register.
    always_comb begin
        pop_o       = wr_i && (sel_i == SEL_LOG) && (wdata_i == DATA_W'(POP_CODE));
        clr_o       = wr_i && (sel_i == SEL_CNT);
        wr_thr      = wr_i && (sel_i == SEL_THR);
        wr_ien      = wr_i && (sel_i == SEL_IEN);
        wr_stat_clr = wr_i && (sel_i == SEL_STAT) && wdata_i[STAT_CE_BIT];
    end

    // Threshold and enable storage.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            thr_q <= CNT_W'(THR_RST);
            ien_q <= 1'b0;
        end else begin
            if (wr_thr) thr_q <= wdata_i[CNT_W-1:0];
            if (wr_ien) ien_q <= wdata_i[0];
        end
    end

    // Sticky status bit: set by a firing, cleared by write-1.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stat_q <= 1'b0;
        end else if (fire_i) begin
            stat_q <= 1'b1;
        end else if (wr_stat_clr) begin
            stat_q <= 1'b0;
        end
    end

    // Read multiplexer for the current select.
    always_comb begin
        rdata_o = '0;
        case (sel_i)
            SEL_LOG:  rdata_o = DATA_W'(head_i);
            SEL_CNT:  rdata_o = DATA_W'(count_i);
            SEL_THR:  rdata_o = DATA_W'(thr_q);
            SEL_STAT: rdata_o[STAT_CE_BIT] = stat_q;
            SEL_IEN:  rdata_o[0] = ien_q;
            default:  rdata_o = '0;
        endcase
    end

    assign thr_o    = thr_q;
    assign status_o = stat_q;
    assign irq_o    = stat_q & ien_q;
endmodule

// File: rtl/ce_err_logger.sv
// Module: ce_err_logger (top)
// Logs correctable ECC event addresses in a small queue, counts events and
// raises a one-shot threshold status and interrupt.
// Assumes: err_valid is a one-cycle strobe per event; escalated multi-word
// single-bit errors arrive on the same input and are treated alike.
module ce_err_logger #(
    parameter int ADDR_W  = 29,
    parameter int CNT_W   = 8,
    parameter int DATA_W  = 32,
    parameter int DEPTH   = 2,
    parameter int THR_RST = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              err_valid,
    input  logic [ADDR_W-1:0] err_addr,
    input  logic              sw_wr,
    input  logic [2:0]        sw_sel,
    input  logic [DATA_W-1:0] sw_wdata,
    output logic [DATA_W-1:0] sw_rdata,
    output logic [ADDR_W-1:0] log_head,
    output logic [CNT_W-1:0]  err_count,
    output logic              status_raw,
    output logic              irq
);
    localparam int LVL_W = $clog2(DEPTH + 1);

    logic             pop;
    logic             clr;
    logic             fire;
    logic [CNT_W-1:0] thr;
    logic [LVL_W-1:0] fifo_level;

    ce_addr_fifo #(.ADDR_W(ADDR_W), .DEPTH(DEPTH)) u_fifo (
        .clk     (clk),
        .rst_n   (rst_n),
        .push_i  (err_valid),
        .addr_i  (err_addr),
        .pop_i   (pop),
        .head_o  (log_head),
        .level_o (fifo_level)
    );

    ce_err_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .inc_i   (err_valid),
        .clr_i   (clr),
        .thr_i   (thr),
        .count_o (err_count),
        .fire_o  (fire)
    );

    ce_sw_regs #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .DATA_W(DATA_W), .THR_RST(THR_RST)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_i     (sw_wr),
        .sel_i    (sw_sel),
        .wdata_i  (sw_wdata),
        .head_i   (log_head),
        .count_i  (err_count),
        .fire_i   (fire),
        .rdata_o  (sw_rdata),
        .pop_o    (pop),
        .clr_o    (clr),
        .thr_o    (thr),
        .status_o (status_raw),
        .irq_o    (irq)
    );
endmodule

// File: rtl/ce_err_logger_chk.sv
// Module: ce_err_logger_chk
// Property checker bound into every ce_err_logger instance.
module ce_err_logger_chk #(
    parameter int ADDR_W = 29,
    parameter int CNT_W  = 8,
    parameter int DEPTH  = 2
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic                       err_valid,
    input logic                       sw_wr,
    input logic [2:0]                 sw_sel,
    input logic [CNT_W-1:0]           err_count,
    input logic                       status_raw,
    input logic [ADDR_W-1:0]          log_head,
    input logic [$clog2(DEPTH+1)-1:0] fifo_level,
    input logic                       fire
);
    import ce_pkg::*;
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    logic clr_w;
    assign clr_w = sw_wr && (sw_sel == SEL_CNT);

    // R4
    cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (err_valid && !clr_w && err_count != CNT_MAX) |=> err_count == $past(err_count) + 1'b1);

    // R8
    cnt_sat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (err_valid && !clr_w && err_count == CNT_MAX) |=> err_count == CNT_MAX);

    // R12
    cnt_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr_w |=> err_count == '0);

    // R5
    stat_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fire |=> status_raw);

    // R10
    empty_head_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fifo_level == '0) |-> (log_head == '0));

    // R1
    level_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_level <= ($clog2(DEPTH+1))'(DEPTH));
endmodule

bind ce_err_logger ce_err_logger_chk #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .DEPTH(DEPTH)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .err_valid  (err_valid),
    .sw_wr      (sw_wr),
    .sw_sel     (sw_sel),
    .err_count  (err_count),
    .status_raw (status_raw),
    .log_head   (log_head),
    .fifo_level (fifo_level),
    .fire       (fire)
);

// File: tb/test_ce_err_logger.sv
module test_ce_err_logger;
    localparam int ADDR_W = 29;
    localparam int CNT_W  = 8;
    localparam int DATA_W = 32;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              err_valid = 1'b0;
    logic [ADDR_W-1:0] err_addr = '0;
    logic              sw_wr = 1'b0;
    logic [2:0]        sw_sel = '0;
    logic [DATA_W-1:0] sw_wdata = '0;
    logic [DATA_W-1:0] sw_rdata;
    logic [ADDR_W-1:0] log_head;
    logic [CNT_W-1:0]  err_count;
    logic              status_raw;
    logic              irq;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;
    string tag = "R1";

    // reference model state
    int m_q[2];
    int m_n, m_cnt, m_thr, m_arm, m_st, m_en;
    int rsel = 0;

    always #4 clk = ~clk;

    ce_err_logger i_ce_err_logger (
        .clk(clk), .rst_n(rst_n), .err_valid(err_valid), .err_addr(err_addr),
        .sw_wr(sw_wr), .sw_sel(sw_sel), .sw_wdata(sw_wdata), .sw_rdata(sw_rdata),
        .log_head(log_head), .err_count(err_count), .status_raw(status_raw), .irq(irq)
    );

    task automatic check(input bit ok, input string what, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    function automatic int exp_rdata(input int s);
        case (s)
            0: return (m_n > 0) ? m_q[0] : 0;
            1: return m_cnt;
            2: return m_thr;
            3: return m_st << 3;
            4: return m_en;
            default: return 0;
        endcase
    endfunction

    task automatic compare();
        int head = (m_n > 0) ? m_q[0] : 0;
        check(log_head == ADDR_W'(head), "log_head (R1/R2)", log_head, head);
        check(err_count == CNT_W'(m_cnt), "err_count (R4)", err_count, m_cnt);
        check(status_raw == m_st[0], "status (R5/R6/R9)", status_raw, m_st);
        check(irq == (m_st[0] & m_en[0]), "irq (R7)", irq, m_st & m_en);
        check(sw_rdata == DATA_W'(exp_rdata(rsel)), $sformatf("rdata sel %0d (R2)", rsel),
              sw_rdata, exp_rdata(rsel));
    endtask

    // One clock: drive at negedge, update model at the edge, compare after.
    task automatic cyc(input bit ev, input int a, input bit wr, input int sel, input int wd);
        int nc;
        bit fire;
        err_valid = ev; err_addr = ADDR_W'(a);
        sw_wr = wr; sw_sel = 3'(sel); sw_wdata = DATA_W'(wd);
        @(posedge clk);
        if (wr && sel == 0 && wd == 1 && m_n > 0) begin
            m_q[0] = m_q[1]; m_n--;
        end
        if (ev && m_n < 2) begin
            m_q[m_n] = a; m_n++;
        end
        fire = 1'b0;
        if (wr && sel == 1) begin
            m_cnt = 0; m_arm = 1;
        end else if (ev) begin
            nc = (m_cnt == 255) ? 255 : m_cnt + 1;
            if (m_arm == 1 && nc >= m_thr) begin
                fire = 1'b1; m_arm = 0;
            end
            m_cnt = nc;
        end
        if (fire) m_st = 1;
        else if (wr && sel == 3 && wd[3]) m_st = 0;
        if (wr && sel == 2) m_thr = wd & 255;
        if (wr && sel == 4) m_en = wd & 1;
        @(negedge clk);
        err_valid = 1'b0; sw_wr = 1'b0;
        rsel = (rsel + 1) % 6;
        sw_sel = 3'(rsel);
        #1;
        compare();
    endtask

    initial begin
        m_n = 0; m_cnt = 0; m_thr = 1; m_arm = 1; m_st = 0; m_en = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        tag = "R1";
        compare();

        // R10: pop on empty queue is ignored, next event becomes head
        tag = "R10";
        cyc(0, 0, 1, 0, 1);
        cyc(1, 77, 0, 0, 0);
        check(log_head == 77, "head after empty pop R10", log_head, 77);
        cyc(0, 0, 1, 0, 1);

        // R3: same address twice gives two entries
        tag = "R3";
        cyc(1, 123, 0, 0, 0);
        cyc(1, 123, 0, 0, 0);
        cyc(0, 0, 1, 0, 1);
        check(log_head == 123, "duplicate entry R3", log_head, 123);
        cyc(0, 0, 1, 0, 1);

        // R1 / R2: full queue drops, non-pop value ignored
        tag = "R1";
        cyc(1, 10, 0, 0, 0);
        cyc(1, 11, 0, 0, 0);
        cyc(1, 12, 0, 0, 0);
        tag = "R2";
        cyc(0, 0, 1, 0, 3);
        check(log_head == 10, "non-pop write R2", log_head, 10);

        // R11: push and pop together on a full queue
        tag = "R11";
        cyc(1, 13, 1, 0, 1);
        cyc(0, 0, 1, 0, 1);
        check(log_head == 13, "push+pop when full R11", log_head, 13);
        cyc(0, 0, 1, 0, 1);

        // R12: clear together with an event
        tag = "R12";
        cyc(1, 5, 1, 1, 0);
        check(err_count == 0, "clear beats event R12", err_count, 0);

        // R6 / R7 / R9: one-shot threshold and write-1-to-clear
        tag = "R6";
        cyc(0, 0, 1, 4, 1);
        cyc(0, 0, 1, 2, 2);
        cyc(0, 0, 1, 3, 8);
        cyc(1, 1, 0, 0, 0);
        cyc(1, 2, 0, 0, 0);
        tag = "R7";
        check(irq == 1, "irq after crossing R7", irq, 1);
        tag = "R9";
        cyc(0, 0, 1, 3, 8);
        check(status_raw == 0, "w1c clears R9", status_raw, 0);
        tag = "R6";
        cyc(1, 3, 0, 0, 0);
        check(status_raw == 0, "no refire R6", status_raw, 0);
        cyc(0, 0, 1, 1, 0);
        cyc(1, 4, 0, 0, 0);
        cyc(1, 4, 0, 0, 0);
        check(status_raw == 1, "refire after clear R6", status_raw, 1);
        tag = "R9";
        cyc(0, 0, 1, 1, 0);
        cyc(1, 4, 0, 0, 0);
        cyc(1, 4, 1, 3, 8);
        check(status_raw == 1, "set beats w1c R9", status_raw, 1);

        // Sweep of thresholds with a dense random mix.
        tag = "R5";
        for (int t = 0; t < 5; t++) begin
            cyc(0, 0, 1, 1, 0);
            cyc(0, 0, 1, 3, 8);
            cyc(0, 0, 1, 2, t);
            for (int k = 0; k < 60; k++) begin
                int r = $urandom_range(0, 15);
                int a = $urandom_range(0, 3) * 4096 + 1;
                case (r)
                    0: cyc(1, a, 1, 1, 0);
                    1, 2: cyc(1, a, 1, 0, 1);
                    3: cyc(0, 0, 1, 0, 1);
                    4: cyc(1, a, 1, 3, 8);
                    5: cyc(0, 0, 1, 4, $urandom_range(0, 1));
                    6: cyc(1, a, 1, 0, 2);
                    default: cyc(r > 9, a, 0, 0, 0);
                endcase
            end
        end

        // R8: saturation
        tag = "R8";
        cyc(0, 0, 1, 1, 0);
        for (int k = 0; k < 260; k++) cyc(1, k, 0, 0, 0);
        check(err_count == 255, "saturated count R8", err_count, 255);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule